// File: doc/BRIEF.md
# USB low-speed packet receiver

This block turns the two USB data lines of a low-speed link into a stream of bytes. Both line inputs are first passed through a two-flop synchroniser. The block then waits for the idle J state. It locks onto the K edges of the sync field, and it only accepts a start once two K bits arrive back to back. Each data bit is then sampled near its centre, with no oversampling logic beyond a small period counter. The bit rate is 1.5 Mbit/s and the clock is 16 MHz, so one bit lasts 10⅔ clocks. The counter handles this by using 11- and 10-clock periods in a fixed pattern over each eight line bits, plus one leap clock every third group.

Sampled levels are NRZI-decoded and stuffed bits are removed. The remaining bits are packed into bytes least significant bit first. Each byte appears as a one-cycle strobe with its data. A start strobe marks the confirmed sync field. At the end of the packet (SE0), an end strobe carries the byte count, or an error strobe with a code reports why the packet is unusable. The consumer treats the bytes of a packet as valid only when the end strobe follows them. After every end or error the receiver returns to hunting for the next packet.

Top module: `usbls_rx`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises with the line idle, `rx_start`, `rx_valid`, `rx_end` and `rx_err` are 0, and `rx_count` and `rx_err_code` are 0.
- R2: Reception begins only after the line has been J (`usb_dm`=1, `usb_dp`=0) and then turns K (`usb_dp`=1, `usb_dm`=0). The sample taken one bit after that edge must also be K. If it is not, no `rx_start` is given for that edge, and the receiver waits for the next K edge.
- R3: After a failed double-K check, if no new K appears within HUNT_WIN (8) clocks, `rx_err` pulses with `rx_err_code` = 1 (sync error) and no byte is delivered.
- R4: A sampled level equal to the previous one decodes as 1, and a change decodes as 0. The first data bit after sync is bit 0 of the byte. Every completed byte gives one `rx_valid` pulse with the byte on `rx_byte`.
- R5: A bit that follows six consecutive decoded 1 bits is dropped and does not count toward the byte. The final 1 of the sync field counts toward that run.
- R6: Sampling uses periods of 11,11,10,11,10,11,10,11 clocks over each eight line bits, with one extra clock on the first period of every third group. This keeps packets of MAX_BYTES (16) bytes aligned to a 10⅔-clock bit.
- R7: SE0 (both lines 0) at a sample point ends the packet. If at least MIN_BYTES (3) bytes were received, `rx_end` pulses once, after the last `rx_valid`, with `rx_count` equal to the number of bytes.
- R8: A packet that ends with fewer than 3 bytes gives `rx_err` with `rx_err_code` = 3 and no `rx_end`.
- R9: Completion of byte MAX_BYTES+1 gives `rx_err` with `rx_err_code` = 2 instead of an `rx_valid`. The rest of the packet up to SE0 is ignored, and no `rx_end` follows.
- R10: `rx_start` pulses exactly once per accepted packet, before its first `rx_valid`. No two of `rx_start`, `rx_valid`, `rx_end`, `rx_err` are high in the same cycle.
- R11: After any end of packet or any error, the next packet on the line is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | D+ line level, asynchronous |
| usb_dm | input | 1 | D- line level, asynchronous |
| rx_start | output | 1 | One-cycle pulse when the sync field is confirmed |
| rx_valid | output | 1 | One-cycle pulse per received byte |
| rx_byte | output | 8 | Received byte, valid with `rx_valid` |
| rx_end | output | 1 | One-cycle pulse on a good end of packet |
| rx_count | output | 5 | Byte count of the last good packet, updated with `rx_end` |
| rx_err | output | 1 | One-cycle pulse on sync error, overflow or short packet |
| rx_err_code | output | 2 | 1 sync, 2 overflow, 3 short; updated with `rx_err` |

## Verification
The bench builds line waveforms bit by bit, with each bit boundary placed at the ideal 10⅔-clock position, so any drift in the sampling cadence shows up as a wrong byte.

- Payloads of all zeros toggle the line on every bit, while alternating patterns and random bytes mix runs and changes. Together they separate correct NRZI polarity and LSB-first packing from a swapped or reversed decode.
- All-ones payloads force a stuffed bit about every seven line bits, which exposes a stuffed bit that is kept or miscounted.
- Full-length packets cross several leap groups and catch a missing leap clock.
- The lengths 0, 2, 3, 16 and 18 bytes sit on both sides of the short and overflow limits.
- A lone K glitch and a sync field without its closing double K separate a correct confirmation from a receiver that starts on any edge.
// File: rtl/usbls_pkg.sv
// Shared types for the low-speed receiver: line states, FSM states, error codes.
package usbls_pkg;

    // Line state as the pair {D+, D-}
    typedef enum logic [1:0] {
        LINE_SE0 = 2'b00,
        LINE_J   = 2'b01,
        LINE_K   = 2'b10,
        LINE_SE1 = 2'b11
    } line_t;

    // Receiver control states
    typedef enum logic [2:0] {
        ST_WAITJ   = 3'd0,
        ST_HUNT    = 3'd1,
        ST_CONFIRM = 3'd2,
        ST_REHUNT  = 3'd3,
        ST_RECV    = 3'd4,
        ST_DRAIN   = 3'd5
    } rx_state_t;

    // Error codes reported on rx_err_code
    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_SYNC     = 2'd1,
        ERR_OVERFLOW = 2'd2,
        ERR_SHORT    = 2'd3
    } rx_err_t;

endpackage
// File: rtl/usbls_sync.sv
// Multi-stage synchroniser for a small bus of asynchronous inputs.
// Assumes each bit is independent and slow relative to clk, so
// per-bit skew of one clock is acceptable.
module usbls_sync #(
    parameter int                 WIDTH   = 2,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule
// File: rtl/usbls_bit_timer.sv
// Bit sample strobe generator for a non-integer clocks-per-bit ratio.
// Over each group of SLOTS line bits, slot 0 and the odd slots last
// SHORT_CLKS+1 clocks and the other even slots SHORT_CLKS clocks.
// Slot 0 of every LEAP_GROUPS-th group gets one more clock.
// Assumes start is raised on the cycle that the previous bit was sampled.
module usbls_bit_timer #(
    parameter int SHORT_CLKS  = 10,
    parameter int SLOTS       = 8,
    parameter int LEAP_GROUPS = 3,
    localparam int CNT_W  = $clog2(SHORT_CLKS + 2),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int GRP_W  = (LEAP_GROUPS > 1) ? $clog2(LEAP_GROUPS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic tick
);

    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [GRP_W-1:0]  grp_q;
    logic [SLOT_W-1:0] slot_nx;
    logic [GRP_W-1:0]  grp_nx;

    // Reload value (period minus one) for a given slot and group
    function automatic logic [CNT_W-1:0] reload(input logic [SLOT_W-1:0] s,
                                                input logic [GRP_W-1:0]  g);
        logic [CNT_W-1:0] p;
        p = CNT_W'(SHORT_CLKS - 1);
        if (s == '0 || s[0]) p = p + 1'b1;
        if (s == '0 && g == GRP_W'(LEAP_GROUPS - 1)) p = p + 1'b1;
        return p;
    endfunction

    assign tick = run && (cnt_q == '0);

    // Next slot and group after the current period ends
    always_comb begin
        slot_nx = slot_q + 1'b1;
        grp_nx  = grp_q;
        if (slot_q == SLOT_W'(SLOTS - 1)) begin
            slot_nx = '0;
            grp_nx  = (grp_q == GRP_W'(LEAP_GROUPS - 1)) ? '0 : grp_q + 1'b1;
        end
    end

    // Count down the current period and reload on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
            grp_q  <= '0;
        end else if (start) begin
            cnt_q  <= reload('0, '0);
            slot_q <= '0;
            grp_q  <= '0;
        end else if (tick) begin
            cnt_q  <= reload(slot_nx, grp_nx);
            slot_q <= slot_nx;
            grp_q  <= grp_nx;
        end else if (run) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R6
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !tick);

endmodule
// File: rtl/usbls_nrzi_unstuff.sv
// NRZI decoder, stuff-bit remover and LSB-first byte packer.
// Acts only on sample strobes. An init pulse primes it with the last
// sync level (K) and a run of one decoded 1. An SE0 at a sample gives
// an end pulse instead of a bit.
module usbls_nrzi_unstuff
    import usbls_pkg::*;
#(
    parameter int STUFF_RUN = 6,
    parameter int BYTE_W    = 8,
    localparam int ONES_W = $clog2(STUFF_RUN + 1),
    localparam int BIT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              tick,
    input  line_t             line,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_data,
    output logic              se0_seen
);

    logic              prev_dm_q;
    logic [ONES_W-1:0] ones_q;
    logic [BIT_W-1:0]  nbits_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              dec_bit;
    logic [BYTE_W-1:0] next_sh;
    logic              is_stuff;

    // Decoded bit and the shift register value it would produce
    always_comb begin
        dec_bit  = (line[0] == prev_dm_q);
        next_sh  = {dec_bit, shreg_q[BYTE_W-1:1]};
        is_stuff = (ones_q == ONES_W'(STUFF_RUN));
    end

    // Decode, unstuff and pack one line bit per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dm_q <= 1'b0;
            ones_q    <= '0;
            nbits_q   <= '0;
            shreg_q   <= '0;
            byte_done <= 1'b0;
            byte_data <= '0;
            se0_seen  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            se0_seen  <= 1'b0;
            if (init) begin
                prev_dm_q <= 1'b0;
                ones_q    <= ONES_W'(1);
                nbits_q   <= '0;
            end else if (tick) begin
                if (line == LINE_SE0) begin
                    se0_seen <= 1'b1;
                end else begin
                    prev_dm_q <= line[0];
                    if (is_stuff) begin
                        ones_q <= '0;
                    end else begin
                        shreg_q <= next_sh;
                        ones_q  <= dec_bit ? ones_q + 1'b1 : '0;
                        if (nbits_q == BIT_W'(BYTE_W - 1)) begin
                            byte_done <= 1'b1;
                            byte_data <= next_sh;
                            nbits_q   <= '0;
                        end else begin
                            nbits_q <= nbits_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R5
    stuff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !init && is_stuff && line != LINE_SE0) |=> (!byte_done && $stable(nbits_q)));

    // R5
    run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= ONES_W'(STUFF_RUN));

    // R7
    end_vs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_done && se0_seen));

endmodule
// File: rtl/usbls_rx.sv
// Low-speed USB packet receiver top. It synchronises D+/D-, finds and
// confirms the sync field, then drives the bit timer and decoder. It
// reports bytes, start, end and error strobes. It assumes the line is
// J between packets and that the clock is 16 MHz for a 1.5 Mbit/s line.
module usbls_rx
    import usbls_pkg::*;
#(
    parameter int MAX_BYTES    = 16,
    parameter int MIN_BYTES    = 3,
    parameter int HUNT_WIN     = 8,
    parameter int CONFIRM_CLKS = 16,
    parameter int SHORT_CLKS   = 10,
    parameter int LEAP_GROUPS  = 3,
    parameter int STUFF_RUN    = 6,
    parameter int BYTE_W       = 8,
    parameter int SYNC_STAGES  = 2,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int WAIT_W = $clog2(((HUNT_WIN > CONFIRM_CLKS) ? HUNT_WIN : CONFIRM_CLKS) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_dp,
    input  logic              usb_dm,
    output logic              rx_start,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_end,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_err,
    output logic [1:0]        rx_err_code
);

    logic [1:0]        line_raw;
    line_t             line_s;
    rx_state_t         state_q;
    logic [WAIT_W-1:0] wait_q;
    logic [CNT_W-1:0]  byte_cnt_q;
    logic              confirm_ok;
    logic              run;
    logic              tick;
    logic              dec_done;
    logic [BYTE_W-1:0] dec_byte;
    logic              dec_se0;

    usbls_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({usb_dp, usb_dm}),
        .q     (line_raw)
    );

    assign line_s = line_t'(line_raw);

    // Sync confirmed: second K seen one bit after the edge
    always_comb begin
        confirm_ok = (state_q == ST_CONFIRM) && (wait_q == WAIT_W'(CONFIRM_CLKS - 1))
                     && (line_s == LINE_K);
        run        = (state_q == ST_RECV);
    end

    usbls_bit_timer #(
        .SHORT_CLKS  (SHORT_CLKS),
        .SLOTS       (BYTE_W),
        .LEAP_GROUPS (LEAP_GROUPS)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (confirm_ok),
        .run   (run),
        .tick  (tick)
    );

    usbls_nrzi_unstuff #(
        .STUFF_RUN (STUFF_RUN),
        .BYTE_W    (BYTE_W)
    ) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (confirm_ok),
        .tick      (tick),
        .line      (line_s),
        .byte_done (dec_done),
        .byte_data (dec_byte),
        .se0_seen  (dec_se0)
    );

    // Packet framing state machine and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_WAITJ;
            wait_q      <= '0;
            byte_cnt_q  <= '0;
            rx_start    <= 1'b0;
            rx_valid    <= 1'b0;
            rx_byte     <= '0;
            rx_end      <= 1'b0;
            rx_count    <= '0;
            rx_err      <= 1'b0;
            rx_err_code <= ERR_NONE;
        end else begin
            rx_start <= 1'b0;
            rx_valid <= 1'b0;
            rx_end   <= 1'b0;
            rx_err   <= 1'b0;
            case (state_q)
                ST_WAITJ: begin
                    if (line_s == LINE_J) state_q <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (line_s == LINE_K) begin
                        state_q <= ST_CONFIRM;
                        wait_q  <= '0;
                    end
                end
                ST_CONFIRM: begin
                    if (wait_q == WAIT_W'(CONFIRM_CLKS - 1)) begin
                        wait_q <= '0;
                        if (confirm_ok) begin
                            state_q    <= ST_RECV;
                            byte_cnt_q <= '0;
                            rx_start   <= 1'b1;
                        end else begin
                            state_q <= ST_REHUNT;
                        end
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_REHUNT: begin
                    if (line_s == LINE_K) begin
                        state_q <= ST_CONFIRM;
                        wait_q  <= '0;
                    end else if (wait_q == WAIT_W'(HUNT_WIN - 1)) begin
                        state_q     <= ST_WAITJ;
                        rx_err      <= 1'b1;
                        rx_err_code <= ERR_SYNC;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_RECV: begin
                    if (dec_done) begin
                        if (byte_cnt_q == CNT_W'(MAX_BYTES)) begin
                            state_q     <= ST_DRAIN;
                            rx_err      <= 1'b1;
                            rx_err_code <= ERR_OVERFLOW;
                        end else begin
                            rx_valid   <= 1'b1;
                            rx_byte    <= dec_byte;
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                        end
                    end else if (dec_se0) begin
                        state_q <= ST_WAITJ;
                        if (byte_cnt_q >= CNT_W'(MIN_BYTES)) begin
                            rx_end   <= 1'b1;
                            rx_count <= byte_cnt_q;
                        end else begin
                            rx_err      <= 1'b1;
                            rx_err_code <= ERR_SHORT;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (line_s == LINE_SE0) state_q <= ST_WAITJ;
                end
                default: state_q <= ST_WAITJ;
            endcase
        end
    end

    // R10
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_start, rx_valid, rx_end, rx_err}));

    // R10
    start_after_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> $past(state_q == ST_CONFIRM));

    // R2
    recv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV && $past(state_q) != ST_RECV) |-> $past(line_s == LINE_K));

    // R9
    byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (byte_cnt_q != '0 && byte_cnt_q <= CNT_W'(MAX_BYTES)));

    // R8
    end_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end |-> (rx_count >= CNT_W'(MIN_BYTES)));

    // R3
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (rx_err_code != ERR_NONE));

endmodule
// File: tb/test_usbls_rx.sv
module test_usbls_rx;

    localparam int MAXB = 16;
    localparam int MINB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_dp = 1'b0;
    logic       usb_dm = 1'b1;
    logic       rx_start, rx_valid, rx_end, rx_err;
    logic [7:0] rx_byte;
    logic [4:0] rx_count;
    logic [1:0] rx_err_code;

    always #5 clk = ~clk;

    usbls_rx i_usbls_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .usb_dp      (usb_dp),
        .usb_dm      (usb_dm),
        .rx_start    (rx_start),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .rx_end      (rx_end),
        .rx_count    (rx_count),
        .rx_err      (rx_err),
        .rx_err_code (rx_err_code)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Line symbols: 0 SE0, 1 J, 2 K as {dp,dm}
    logic [1:0] sym [0:255];
    int         nsym;
    logic [7:0] pl [0:31];
    int         lvl_k;
    int         ones;

    // Monitor record
    logic [7:0] got [0:63];
    int n_got, n_start, n_end, n_err, end_cnt, err_code, order_bad;

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_got = 0; n_start = 0; n_end = 0; n_err = 0;
        end_cnt = -1; err_code = -1; order_bad = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (n_start == 0 || n_end > 0) order_bad++;
                if (n_got < 64) got[n_got] = rx_byte;
                n_got++;
            end
            if (rx_start) n_start++;
            if (rx_end) begin n_end++; end_cnt = int'(rx_count); end
            if (rx_err) begin n_err++; err_code = int'(rx_err_code); end
        end
    end

    task automatic push_sym(input logic [1:0] s);
        sym[nsym] = s;
        nsym++;
    endtask

    // NRZI encode one bit with stuffing after six ones
    task automatic put_bit(input bit b);
        if (!b) lvl_k = 1 - lvl_k;
        push_sym(lvl_k ? 2'b10 : 2'b01);
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
            lvl_k = 1 - lvl_k;
            push_sym(lvl_k ? 2'b10 : 2'b01);
            ones = 0;
        end
    endtask

    task automatic build(input int nb);
        logic [7:0] sy;
        nsym = 0; lvl_k = 0; ones = 0;
        sy = 8'h80;
        for (int i = 0; i < 8; i++) put_bit(sy[i]);
        for (int j = 0; j < nb; j++)
            for (int i = 0; i < 8; i++) put_bit(pl[j][i]);
        push_sym(2'b00); push_sym(2'b00); push_sym(2'b01);
    endtask

    // Drive symbols with ideal 32/3-clock bit boundaries, then idle J
    task automatic drive();
        int ncl;
        ncl = (nsym * 32 + 2) / 3;
        for (int c = 0; c < ncl; c++) begin
            @(negedge clk);
            {usb_dp, usb_dm} = sym[(c * 3) / 32];
        end
        repeat (60) begin
            @(negedge clk);
            {usb_dp, usb_dm} = 2'b01;
        end
    endtask

    // Send a packet of nb payload bytes and compare against expectations
    task automatic run_packet(input int nb, input string req);
        int exp_v, bad;
        clear_mon();
        build(nb);
        drive();
        exp_v = (nb > MAXB) ? MAXB : nb;
        check_eq({req, " byte count"}, n_got, exp_v);
        bad = 0;
        for (int i = 0; i < exp_v && i < n_got; i++) if (got[i] !== pl[i]) bad++;
        check_eq({req, " byte values"}, bad, 0);
        check_eq("R10 start pulses", n_start, 1);
        check_eq("R10 R7 strobe order", order_bad, 0);
        if (nb > MAXB) begin
            check_eq("R9 overflow err", n_err, 1);
            check_eq("R9 overflow code", err_code, 2);
            check_eq("R9 no end", n_end, 0);
        end else if (nb < MINB) begin
            check_eq("R8 short err", n_err, 1);
            check_eq("R8 short code", err_code, 3);
            check_eq("R8 no end", n_end, 0);
        end else begin
            check_eq("R7 end pulses", n_end, 1);
            check_eq("R7 end count", end_cnt, nb);
            check_eq("R7 no err", n_err, 0);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int r;
        r = $urandom(32'd7151);
        clear_mon();
        // R1: reset state
        repeat (4) @(negedge clk);
        check_eq("R1 strobes in reset", int'({rx_start, rx_valid, rx_end, rx_err}), 0);
        check_eq("R1 count in reset", int'(rx_count), 0);
        check_eq("R1 code in reset", int'(rx_err_code), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_eq("R1 idle after reset", n_start + n_got + n_end + n_err, 0);

        // R4: directed patterns
        pl[0] = 8'h00; pl[1] = 8'h55; pl[2] = 8'hAA; pl[3] = 8'h12; pl[4] = 8'h80;
        run_packet(5, "R4 directed");
        // R5: stuffing heavy
        for (int i = 0; i < 8; i++) pl[i] = 8'hFF;
        run_packet(8, "R5 all ones");
        pl[0] = 8'h7E; pl[1] = 8'hFC; pl[2] = 8'h3F; pl[3] = 8'hFE;
        run_packet(4, "R5 runs");
        // R6: full length packet
        for (int i = 0; i < MAXB; i++) pl[i] = 8'($urandom_range(255));
        run_packet(MAXB, "R6 full length");
        // R8 boundaries
        pl[0] = 8'hC3; pl[1] = 8'h5A; pl[2] = 8'h01;
        run_packet(3, "R8 minimum ok");
        run_packet(2, "R8 two bytes");
        run_packet(0, "R8 empty");
        // R9 overflow, then R11 recovery
        for (int i = 0; i < MAXB + 2; i++) pl[i] = 8'($urandom_range(255));
        run_packet(MAXB + 2, "R9 overflow");
        pl[0] = 8'h2D; pl[1] = 8'h00; pl[2] = 8'h10;
        run_packet(3, "R11 after overflow");

        // R3: lone K glitch
        clear_mon();
        nsym = 0; push_sym(2'b10); push_sym(2'b01); push_sym(2'b01); push_sym(2'b01);
        drive();
        check_eq("R3 sync err", n_err, 1);
        check_eq("R3 sync code", err_code, 1);
        check_eq("R3 no bytes", n_got, 0);
        check_eq("R2 no start on glitch", n_start, 0);
        // R2: sync field without closing double K
        clear_mon();
        nsym = 0;
        for (int i = 0; i < 3; i++) begin push_sym(2'b10); push_sym(2'b01); end
        push_sym(2'b01); push_sym(2'b01);
        drive();
        check_eq("R2 no start without KK", n_start, 0);
        check_eq("R2 sync err code", err_code, 1);
        pl[0] = 8'hE1; pl[1] = 8'h9C; pl[2] = 8'h44; pl[3] = 8'h0F;
        run_packet(4, "R11 after sync error");

        // Random packets
        for (int p = 0; p < 16; p++) begin
            int nb;
            nb = MINB + int'($urandom_range(MAXB - MINB));
            for (int i = 0; i < nb; i++) pl[i] = 8'($urandom_range(255));
            run_packet(nb, "R4 R6 random");
        end
        finish_run();
    end

endmodule